// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block sits between configuration logic and an abstract eight-input converter core. It picks the channel to convert, raises a one-cycle request to the core, and waits for the core's done strobe. When the strobe arrives it captures the returned code into a result register, either at full 10-bit width or reduced to 8 bits, and sets an interrupt flag.

Four sequencing modes are available. One-shot converts a single channel. Scan converts a run of channels once. Loop repeats a channel run with no further start requests. Pause converts one channel and then holds until the next start event. A sequence starts from a software strobe or from a rising edge on an external trigger pin. The converter core, its sample-and-hold and its references lie outside the block.

Top module: `adc_seq`

## Requirements
- R1: The block addresses 8 channels through a 3-bit `conv_ch`. `conv_req` is a one-cycle pulse issued the cycle after a start event is accepted, and only one conversion is outstanding at a time.
- R2: With `cfg_res10`=1 the stored `result` equals the 10-bit core code. With `cfg_res10`=0, `result[7:0]` holds code bits 9..2 and `result[9:8]` reads 0.
- R3: Mode 2'b00 (one-shot) converts channel `cfg_ch_lo` exactly once and then returns to idle with `busy` low.
- R4: Mode 2'b01 (scan) converts `cfg_ch_lo`, then each following channel (7 wraps to 0) up to and including `cfg_ch_hi`, once each in that order, and then goes idle.
- R5: Mode 2'b10 (loop) converts the same run as scan, but after `cfg_ch_hi` it restarts at `cfg_ch_lo` without any new start event. It keeps going until stopped.
- R6: Mode 2'b11 (pause) converts one channel of the run, then waits with `busy` high until the next start event, then converts the next channel of the run. The run wraps from `cfg_ch_hi` to `cfg_ch_lo`.
- R7: `busy` rises the cycle after an accepted start and falls when the final result of the sequence is stored. A start event that arrives while a conversion is pending or in flight is ignored. Configuration inputs are held stable while `busy` is high.
- R8: With `trig_en`=1, a rising edge of `ext_trig` acts as a start event after a two-flop synchroniser and an edge detector. With `trig_en`=0 the pin has no effect.
- R9: `irq` sets on every stored result and stays set until `irq_clr`. A store in the same cycle as `irq_clr` wins.
- R10: `sw_stop` ends a loop or pause sequence. The block goes idle at once when it is holding. Otherwise it goes idle after the result of the current conversion is stored.
- R11: `result_vld` is a one-cycle pulse in the cycle after `conv_done`, and it carries `result` and `result_ch` for that conversion.
- R12: After reset `busy`, `irq`, `conv_req`, `result_vld` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Sequencing mode |
| cfg_res10 | input | 1 | 1: 10-bit result, 0: 8-bit result |
| cfg_ch_lo | input | 3 | First channel of the run |
| cfg_ch_hi | input | 3 | Last channel of the run |
| sw_start | input | 1 | Software start strobe |
| sw_stop | input | 1 | Stop strobe for loop and pause modes |
| trig_en | input | 1 | Enables the external trigger |
| ext_trig | input | 1 | Asynchronous external trigger |
| irq_clr | input | 1 | Clears the interrupt flag |
| conv_req | output | 1 | Conversion request to the core |
| conv_ch | output | 3 | Channel to convert |
| conv_done | input | 1 | Core done strobe |
| conv_code | input | 10 | Core output code |
| busy | output | 1 | Sequence active |
| result | output | 10 | Stored conversion result |
| result_ch | output | 3 | Channel of the stored result |
| result_vld | output | 1 | New-result pulse |
| irq | output | 1 | Interrupt request flag |

## Verification
The bench runs scans whose range wraps from channel 7 back to 0. A design that compared channels without modular wrap would either stop at 7 or never end. It pulses a software start in the middle of a running scan. A design that failed to ignore it would restart at the low channel, and the in-order channel check would catch that. In pause mode it waits well beyond the converter latency and checks that no extra result appears and that `busy` stays high, then stops from the hold state and expects idle on the next cycle. It also toggles the trigger pin with the trigger disabled and checks the 8-bit results for zeroed upper bits, which catch a design that lets the pin start a sequence or takes the low code bits.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    MODE_ONCE  = 2'b00,
    MODE_SCAN  = 2'b01,
    MODE_LOOP  = 2'b10,
    MODE_PAUSE = 2'b11
  } seq_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_WAIT = 2'b10,
    ST_HOLD = 2'b11
  } seq_state_e;
endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_en,
  input  logic ext_trig,
  output logic trig_evt
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], ext_trig};
    prev_d = sync_q[TOP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign trig_evt = trig_en & sync_q[TOP] & ~prev_q;

  // R8: an edge yields a single start pulse
  p_trig_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt |=> !trig_evt);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     cfg_mode,
  input  logic [CHW-1:0] cfg_ch_lo,
  input  logic [CHW-1:0] cfg_ch_hi,
  input  logic           start_evt,
  input  logic           sw_stop,
  input  logic           conv_done,
  output logic           conv_req,
  output logic [CHW-1:0] conv_ch,
  output logic           busy,
  output logic           store_en
);
  seq_state_e     state_q, state_d;
  logic [CHW-1:0] ch_q, ch_d, ch_nxt;
  logic           stop_q, stop_d;
  logic           last_conv;
  seq_mode_e      mode;

  assign mode = seq_mode_e'(cfg_mode);

  always_comb begin
    if (ch_q == cfg_ch_hi)                 ch_nxt = cfg_ch_lo;
    else if (ch_q == CHW'(NCH - 1))        ch_nxt = '0;
    else                                   ch_nxt = ch_q + 1'b1;
  end

  always_comb begin
    last_conv = (mode == MODE_ONCE) ||
                ((mode == MODE_SCAN) && (ch_q == cfg_ch_hi));
  end

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    stop_d  = stop_q;
    case (state_q)
      ST_IDLE: begin
        stop_d = 1'b0;
        if (start_evt) begin
          ch_d    = cfg_ch_lo;
          state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        if (sw_stop) stop_d = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (sw_stop) stop_d = 1'b1;
        if (conv_done) begin
          if (last_conv || stop_q || sw_stop) begin
            state_d = ST_IDLE;
          end else begin
            ch_d    = ch_nxt;
            state_d = (mode == MODE_PAUSE) ? ST_HOLD : ST_REQ;
          end
        end
      end
      ST_HOLD: begin
        if (sw_stop)        state_d = ST_IDLE;
        else if (start_evt) state_d = ST_REQ;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      stop_q  <= stop_d;
    end
  end

  assign conv_req = (state_q == ST_REQ);
  assign conv_ch  = ch_q;
  assign busy     = (state_q != ST_IDLE);
  assign store_en = (state_q == ST_WAIT) && conv_done;

  // R3: no request appears from idle without a start event
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_evt) |=> !conv_req);

  // R4: scan requests stay inside a non-wrapping range
  p_scan_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && mode == MODE_SCAN && cfg_ch_lo <= cfg_ch_hi)
      |-> (conv_ch >= cfg_ch_lo && conv_ch <= cfg_ch_hi));

  // R7: a conversion in flight keeps its channel despite new starts
  p_ch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !conv_done) |=> $stable(conv_ch));

  // R10: stop while holding leaves the sequence at once
  p_stop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && sw_stop) |=> !busy);
endmodule

// File: rtl/adc_seq_store.sv
module adc_seq_store #(
  parameter int CODE_W   = 10,
  parameter int NARROW_W = 8,
  parameter int CHW      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_en,
  input  logic [CODE_W-1:0] code,
  input  logic [CHW-1:0]    ch,
  input  logic              res10,
  input  logic              irq_clr,
  output logic [CODE_W-1:0] result,
  output logic [CHW-1:0]    result_ch,
  output logic              result_vld,
  output logic              irq
);
  localparam int PAD_W = CODE_W - NARROW_W;

  logic [CODE_W-1:0] res_q, res_d, narrow;
  logic [CHW-1:0]    rch_q, rch_d;
  logic              vld_q, irq_q, irq_d;

  generate
    if (PAD_W > 0) begin : g_pad
      assign narrow = {{PAD_W{1'b0}}, code[CODE_W-1 -: NARROW_W]};
    end else begin : g_nopad
      assign narrow = code;
    end
  endgenerate

  always_comb begin
    res_d = res_q;
    rch_d = rch_q;
    if (store_en) begin
      res_d = res10 ? code : narrow;
      rch_d = ch;
    end
    if (store_en)     irq_d = 1'b1;
    else if (irq_clr) irq_d = 1'b0;
    else              irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      rch_q <= '0;
      vld_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      res_q <= res_d;
      rch_q <= rch_d;
      vld_q <= store_en;
      irq_q <= irq_d;
    end
  end

  assign result     = res_q;
  assign result_ch  = rch_q;
  assign result_vld = vld_q;
  assign irq        = irq_q;

  // R9: flag persists until cleared
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  // R9: flag only rises with a stored result
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> result_vld);

  // R11: new-result strobe lasts one cycle
  p_vld_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |=> !result_vld);
endmodule

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int NCH      = 8,
  parameter int CODE_W   = 10,
  parameter int NARROW_W = 8,
  localparam int CHW     = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_res10,
  input  logic [CHW-1:0]    cfg_ch_lo,
  input  logic [CHW-1:0]    cfg_ch_hi,
  input  logic              sw_start,
  input  logic              sw_stop,
  input  logic              trig_en,
  input  logic              ext_trig,
  input  logic              irq_clr,
  output logic              conv_req,
  output logic [CHW-1:0]    conv_ch,
  input  logic              conv_done,
  input  logic [CODE_W-1:0] conv_code,
  output logic              busy,
  output logic [CODE_W-1:0] result,
  output logic [CHW-1:0]    result_ch,
  output logic              result_vld,
  output logic              irq
);
  logic trig_evt, start_evt, store_en;

  assign start_evt = sw_start | trig_evt;

  adc_seq_trig #(.SYNC_STAGES(2)) u_trig (
    .clk(clk), .rst_n(rst_n), .trig_en(trig_en),
    .ext_trig(ext_trig), .trig_evt(trig_evt)
  );

  adc_seq_ctrl #(.NCH(NCH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .cfg_ch_lo(cfg_ch_lo), .cfg_ch_hi(cfg_ch_hi),
    .start_evt(start_evt), .sw_stop(sw_stop), .conv_done(conv_done),
    .conv_req(conv_req), .conv_ch(conv_ch), .busy(busy),
    .store_en(store_en)
  );

  adc_seq_store #(.CODE_W(CODE_W), .NARROW_W(NARROW_W), .CHW(CHW)) u_store (
    .clk(clk), .rst_n(rst_n), .store_en(store_en), .code(conv_code),
    .ch(conv_ch), .res10(cfg_res10), .irq_clr(irq_clr),
    .result(result), .result_ch(result_ch), .result_vld(result_vld),
    .irq(irq)
  );

  // R2: narrow results never carry upper bits
  p_narrow_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (result_vld && !cfg_res10 && $stable(cfg_res10))
      |-> (result[CODE_W-1:NARROW_W] == '0));

  // R1: a request is only issued inside an active sequence
  p_req_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> busy);
endmodule

// File: tb/sim_adc_seq.sv
module sim_adc_seq;
  localparam int LAT = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cfg_mode;
  logic       cfg_res10;
  logic [2:0] cfg_ch_lo, cfg_ch_hi;
  logic       sw_start, sw_stop, trig_en, ext_trig, irq_clr;
  logic       conv_req, conv_done, busy, result_vld, irq;
  logic [2:0] conv_ch, result_ch;
  logic [9:0] conv_code, result;

  int n_chk = 0, n_fail = 0;
  int issued = 0, res_cnt = 0;
  int stub_cnt = 0;
  logic [2:0] stub_ch;
  logic [2:0] m_ch;
  logic       prev_vld = 1'b0;
  int cyc = 0;

  always #4 clk = ~clk;

  adc_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_res10(cfg_res10),
    .cfg_ch_lo(cfg_ch_lo), .cfg_ch_hi(cfg_ch_hi), .sw_start(sw_start),
    .sw_stop(sw_stop), .trig_en(trig_en), .ext_trig(ext_trig),
    .irq_clr(irq_clr), .conv_req(conv_req), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_code(conv_code), .busy(busy),
    .result(result), .result_ch(result_ch), .result_vld(result_vld),
    .irq(irq)
  );

  function automatic logic [9:0] stub_code(logic [2:0] ch, int idx);
    return 10'((int'(ch) * 97 + idx * 13 + 5) & 32'h3ff);
  endfunction

  function automatic logic [9:0] fmt(logic [9:0] c, logic wide);
    return wide ? c : {2'b00, c[9:2]};
  endfunction

  function automatic logic [2:0] nxt(logic [2:0] c, logic [2:0] lo, logic [2:0] hi);
    return (c == hi) ? lo : 3'(c + 3'd1);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // converter stub: answers each request after LAT cycles
  always @(negedge clk) begin
    cyc++;
    if (stub_cnt > 0) begin
      stub_cnt--;
      if (stub_cnt == 0) begin
        conv_done = 1'b1;
        conv_code = stub_code(stub_ch, issued);
        issued++;
      end
    end else begin
      conv_done = 1'b0;
    end
    if (conv_req) begin
      stub_ch  = conv_ch;
      stub_cnt = LAT;
    end
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  // result monitor: order of channels and formatting
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (result_vld) begin
        check(result_ch == m_ch, "R1 channel order", int'(result_ch), int'(m_ch));
        check(result == fmt(stub_code(m_ch, res_cnt), cfg_res10), "R2 result value",
              int'(result), int'(fmt(stub_code(m_ch, res_cnt), cfg_res10)));
        check(!prev_vld, "R11 single pulse", int'(prev_vld), 0);
        res_cnt++;
        m_ch = nxt(m_ch, cfg_ch_lo, cfg_ch_hi);
      end
      prev_vld = result_vld;
    end
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); sw_stop = 1'b1;
    @(negedge clk); sw_stop = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); ext_trig = 1'b1;
    cycles(4);
    ext_trig = 1'b0;
  endtask

  task automatic setup(logic [1:0] md, logic [2:0] lo, logic [2:0] hi, logic wide);
    @(negedge clk);
    cfg_mode = md; cfg_ch_lo = lo; cfg_ch_hi = hi; cfg_res10 = wide;
    m_ch = lo;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_results(int target);
    for (int i = 0; i < 3000 && res_cnt < target; i++) @(negedge clk);
  endtask

  initial begin
    int base;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sw_start = 0; sw_stop = 0; trig_en = 0; ext_trig = 0; irq_clr = 0;
    conv_done = 0; conv_code = '0; cfg_mode = 0; cfg_res10 = 1; cfg_ch_lo = 0; cfg_ch_hi = 0;
    m_ch = 0;
    cycles(3);
    // R12 reset state
    check(busy == 0, "R12 busy", busy, 0);
    check(irq == 0, "R12 irq", irq, 0);
    check(conv_req == 0, "R12 conv_req", conv_req, 0);
    check(result_vld == 0 && result == 0, "R12 result", int'(result), 0);
    rst_n = 1'b1;
    cycles(2);

    // R3 one-shot on channel 5, 10-bit
    setup(2'b00, 3'd5, 3'd1, 1'b1);
    base = res_cnt;
    pulse_start();
    check(busy == 1, "R7 busy after start", busy, 1);
    wait_idle();
    check(res_cnt - base == 1, "R3 one result", res_cnt - base, 1);
    check(busy == 0, "R3 idle after", busy, 0);
    check(irq == 1, "R9 irq set", irq, 1);

    // R4 scan 2..6, 8-bit, with an ignored mid-run start (R7)
    setup(2'b01, 3'd2, 3'd6, 1'b0);
    base = res_cnt;
    pulse_start();
    wait_results(base + 1);
    pulse_start();
    wait_idle();
    check(res_cnt - base == 5, "R7 start ignored while busy, R4 count", res_cnt - base, 5);
    check(result[9:8] == 0, "R2 narrow upper zero", int'(result[9:8]), 0);

    // R4 wrapping scan 6..1
    setup(2'b01, 3'd6, 3'd1, 1'b1);
    base = res_cnt;
    pulse_start();
    wait_idle();
    check(res_cnt - base == 4, "R4 wrap count", res_cnt - base, 4);

    // R8 trigger disabled: no effect
    setup(2'b01, 3'd0, 3'd7, 1'b1);
    base = res_cnt;
    pulse_trig();
    cycles(20);
    check(busy == 0 && res_cnt == base, "R8 trigger ignored when disabled", res_cnt - base, 0);

    // R8 trigger enabled: full scan 0..7
    trig_en = 1'b1;
    pulse_trig();
    cycles(2);
    check(busy == 1, "R8 trigger starts", busy, 1);
    wait_idle();
    check(res_cnt - base == 8, "R8 full scan count", res_cnt - base, 8);
    trig_en = 1'b0;

    // R5 loop 3..4, stopped after five results (R10)
    setup(2'b10, 3'd3, 3'd4, 1'b0);
    base = res_cnt;
    pulse_start();
    wait_results(base + 5);
    check(busy == 1, "R5 still running without start", busy, 1);
    pulse_stop();
    wait_idle();
    base = res_cnt;
    cycles(30);
    check(busy == 0 && res_cnt == base, "R10 loop stopped", res_cnt - base, 0);

    // R6 pause mode 7..0 with wrap
    setup(2'b11, 3'd7, 3'd0, 1'b1);
    base = res_cnt;
    pulse_start();
    wait_results(base + 1);
    cycles(25);
    check(busy == 1 && res_cnt == base + 1, "R6 holds after one", res_cnt - base, 1);
    pulse_start();
    wait_results(base + 2);
    cycles(25);
    check(res_cnt == base + 2, "R6 second step", res_cnt - base, 2);
    pulse_start();
    wait_results(base + 3);
    cycles(10);
    check(busy == 1, "R6 busy in hold", busy, 1);
    @(negedge clk); sw_stop = 1'b1;
    @(negedge clk); sw_stop = 1'b0;
    check(busy == 0, "R10 stop from hold", busy, 0);

    // R9 clear and hold-off
    check(irq == 1, "R9 irq held", irq, 1);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    check(irq == 0, "R9 irq cleared", irq, 0);
    cycles(10);
    check(irq == 0, "R9 irq stays clear", irq, 0);

    // random one-shot / scan runs, software or trigger start
    for (int k = 0; k < 12; k++) begin
      logic [1:0] md;
      logic [2:0] lo, hi;
      logic wide, use_trig;
      int exp_n;
      md = 2'($urandom % 2);
      lo = 3'($urandom); hi = 3'($urandom);
      wide = 1'($urandom); use_trig = 1'($urandom);
      exp_n = (md == 2'b00) ? 1 : ((int'(hi) - int'(lo)) & 7) + 1;
      setup(md, lo, hi, wide);
      base = res_cnt;
      if (use_trig) begin
        trig_en = 1'b1;
        pulse_trig();
        cycles(2);
      end else begin
        pulse_start();
      end
      wait_idle();
      trig_en = 1'b0;
      check(res_cnt - base == exp_n, "R4 random run count", res_cnt - base, exp_n);
    end

    finish_run();
  end
endmodule